// File: doc/BRIEF.md
# Push-Button Debouncer with Brightness Chord

This block conditions five active-low push buttons (INT, LEFT, UP, DOWN, RIGHT). On each pulse of a sample tick it shifts every raw key level into a per-key history register. From that history it reports a debounced held level for each key. It also reports a sticky press flag for each key. A press counts only when a long run of released samples ends in a single pressed sample, so contact bounce is rejected. Software reads the press flags and clears them with a mask input.

The block also keeps a brightness level. While LEFT and RIGHT are both held, a fresh UP press raises the level by one step and a fresh DOWN press lowers it by one step. The press that drives the step is absorbed and does not appear as a flag. Each real change of level raises a one-cycle store strobe that carries the new value, so that a non-volatile store can write it to its byte at address zero. The level stops at its minimum and maximum values.

Top module: `key_debounce_top`

## Requirements
- R1: A key's history register changes only on a cycle where `tick_i` is high. On that tick it shifts left by one and takes the raw key level into bit 0, where 0 means pressed.
- R2: A press is recognised only when, after a tick, the history equals all ones except bit 0 (8'b1111_1110 at the default width). A pressed sample that follows a shorter released run is not a press. Holding a key raises no further presses.
- R3: Each recognised press sets one bit of `edge_o`: bit 0 for INT, 1 for LEFT, 2 for UP, 3 for DOWN and 4 for RIGHT. The bit is visible on the cycle after the sampling tick.
- R4: Press flags stay set until the matching bit of `edge_clr_i` is high for a cycle. A set and a clear of the same bit in the same cycle leave the bit set.
- R5: `held_o[k]` is 1 exactly when bit 0 of key k's history is 0.
- R6: When LEFT and RIGHT are both held, an UP press raises `bright_o` by one and a DOWN press lowers it by one. Without both held, UP and DOWN presses leave `bright_o` unchanged.
- R7: Every change of `bright_o` is joined by a one-cycle `store_o` pulse in the same cycle, with `store_val_o` equal to the new level.
- R8: The level saturates at 0 and at 2**BRIGHT_W-1. A step that would pass either limit changes nothing and raises no `store_o`.
- R9: An UP or DOWN press used to step the brightness does not set its bit in `edge_o`.
- R10: Reset loads every history with all ones. It clears all flags and `store_o` and loads `bright_o` with BRIGHT_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Sample strobe; one history shift per high cycle |
| key_n_i | input | 5 | Raw key levels, 0 = pressed, bit order as R3 |
| edge_clr_i | input | 5 | Per-key press flag clear mask |
| held_o | output | 5 | Debounced held level, 1 = held |
| edge_o | output | 5 | Sticky press flags |
| bright_o | output | BRIGHT_W | Current brightness level |
| store_o | output | 1 | One-cycle strobe on each brightness change |
| store_val_o | output | BRIGHT_W | Value to store at non-volatile address 0 |

## Verification
The bench keeps the default eight-sample history and four-bit level. It overrides BRIGHT_INIT to 13, so the ceiling is reached after two chord presses and the saturated case can be checked right away. The floor is reached by a run of DOWN chord presses from the top. Press patterns are built one tick at a time, so both a clean seven-release run and a short bounce run can be placed in front of a pressed sample.

// File: rtl/keypad_pkg.sv
package keypad_pkg;
    localparam int NUM_KEYS = 5;
    localparam int K_INT    = 0;
    localparam int K_LEFT   = 1;
    localparam int K_UP     = 2;
    localparam int K_DOWN   = 3;
    localparam int K_RIGHT  = 4;
endpackage

// File: rtl/key_history.sv
module key_history #(
    parameter int HIST_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_n_i,
    output logic held_o,
    output logic press_o
);
    localparam logic [HIST_W-1:0] IDLE_PAT  = '1;
    localparam logic [HIST_W-1:0] PRESS_PAT = {{(HIST_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic              press;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.press = 1'b0;
        if (tick_i) begin
            st_d.hist  = {st_q.hist[HIST_W-2:0], raw_n_i};
            st_d.press = (st_d.hist == PRESS_PAT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hist  <= IDLE_PAT;
            st_q.press <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_o  = ~st_q.hist[0];
    assign press_o = st_q.press;

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.hist)); // R1
    AST_PRESS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        press_o |-> held_o); // R2
    AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        press_o |=> !press_o); // R2
endmodule

// File: rtl/bright_step.sv
module bright_step #(
    parameter int BRIGHT_W    = 4,
    parameter int BRIGHT_INIT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc_i,
    input  logic                dec_i,
    output logic [BRIGHT_W-1:0] level_o,
    output logic                store_o
);
    localparam logic [BRIGHT_W-1:0] LVL_MAX  = '1;
    localparam logic [BRIGHT_W-1:0] LVL_MIN  = '0;
    localparam logic [BRIGHT_W-1:0] LVL_INIT = BRIGHT_W'(BRIGHT_INIT);

    typedef struct packed {
        logic [BRIGHT_W-1:0] level;
        logic                store;
    } lvl_state_t;

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.store = 1'b0;
        if (inc_i && !dec_i && st_q.level != LVL_MAX) begin
            st_d.level = st_q.level + 1'b1;
            st_d.store = 1'b1;
        end else if (dec_i && !inc_i && st_q.level != LVL_MIN) begin
            st_d.level = st_q.level - 1'b1;
            st_d.store = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.level <= LVL_INIT;
            st_q.store <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
    assign store_o = st_q.store;

    AST_STORE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        store_o |-> (level_o != $past(level_o))); // R7
    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(level_o) == LVL_MAX) |-> (level_o != LVL_MIN)); // R8
    AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(level_o) == LVL_MIN) |-> (level_o != LVL_MAX)); // R8
endmodule

// File: rtl/key_debounce_top.sv
module key_debounce_top
    import keypad_pkg::*;
#(
    parameter int HIST_W      = 8,
    parameter int BRIGHT_W    = 4,
    parameter int BRIGHT_INIT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [4:0]          key_n_i,
    input  logic [4:0]          edge_clr_i,
    output logic [4:0]          held_o,
    output logic [4:0]          edge_o,
    output logic [BRIGHT_W-1:0] bright_o,
    output logic                store_o,
    output logic [BRIGHT_W-1:0] store_val_o
);
    typedef struct packed {
        logic [NUM_KEYS-1:0] flags;
    } edge_state_t;

    edge_state_t st_d, st_q;

    logic [NUM_KEYS-1:0] held_w;
    logic [NUM_KEYS-1:0] press_w;
    logic [NUM_KEYS-1:0] absorb_w;
    logic                chord_w;
    logic                step_up_w;
    logic                step_dn_w;

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        key_history #(.HIST_W(HIST_W)) u_hist (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .raw_n_i(key_n_i[k]),
            .held_o (held_w[k]),
            .press_o(press_w[k])
        );
    end

    always_comb begin
        chord_w   = held_w[K_LEFT] & held_w[K_RIGHT];
        step_up_w = chord_w & press_w[K_UP];
        step_dn_w = chord_w & press_w[K_DOWN];
        absorb_w  = '0;
        absorb_w[K_UP]   = step_up_w;
        absorb_w[K_DOWN] = step_dn_w;
        st_d.flags = (st_q.flags & ~edge_clr_i) | (press_w & ~absorb_w);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flags <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    bright_step #(.BRIGHT_W(BRIGHT_W), .BRIGHT_INIT(BRIGHT_INIT)) u_bright (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (step_up_w),
        .dec_i  (step_dn_w),
        .level_o(bright_o),
        .store_o(store_o)
    );

    assign held_o      = held_w;
    assign edge_o      = st_q.flags;
    assign store_val_o = bright_o;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        |(st_q.flags & ~edge_clr_i) |=>
        ((st_q.flags & $past(st_q.flags & ~edge_clr_i)) == $past(st_q.flags & ~edge_clr_i))); // R4
    AST_CHORD_ABSORB: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up_w && !st_q.flags[K_UP]) |=> !st_q.flags[K_UP]); // R9
    AST_NO_CHORD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !chord_w |=> !store_o); // R6
endmodule

// File: tb/sim_key_debounce_top.sv
module sim_key_debounce_top;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 8;
    localparam int BW = 4;
    localparam logic [4:0] M_INT = 5'b00001, M_LEFT = 5'b00010, M_UP = 5'b00100,
                           M_DOWN = 5'b01000, M_RIGHT = 5'b10000;

    logic clk = 0, rst_n = 0, tick = 0;
    logic [4:0] key_n = '1, clr = '0;
    logic [4:0] held, edges;
    logic [BW-1:0] bright, sval;
    logic store;
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    key_debounce_top #(.HIST_W(HW), .BRIGHT_W(BW), .BRIGHT_INIT(13)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .key_n_i(key_n),
        .edge_clr_i(clr), .held_o(held), .edge_o(edges), .bright_o(bright),
        .store_o(store), .store_val_o(sval));

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one tick with the given keys down; ends after the cycle that shows flags
    task automatic sample(input logic [4:0] hold, input logic [4:0] key);
        @(negedge clk); key_n = ~(hold | key); tick = 1;
        @(negedge clk); tick = 0;
        @(negedge clk);
    endtask

    task automatic press(input logic [4:0] hold, input logic [4:0] key);
        for (int i = 0; i < HW-1; i++) sample(hold, 5'b0);
        sample(hold, key);
    endtask

    task automatic clear(input logic [4:0] m);
        @(negedge clk); clr = m;
        @(negedge clk); clr = '0;
    endtask

    task automatic t_reset;
        check("R10 held", held, 0);
        check("R10 edge", edges, 0);
        check("R10 bright", bright, 13);
        check("R10 store", store, 0);
    endtask

    task automatic t_no_tick;
        @(negedge clk); key_n = '0;
        repeat (4) @(negedge clk);
        check("R1 held without tick", held, 0);
        check("R1 edge without tick", edges, 0);
        key_n = '1;
    endtask

    task automatic t_int_press;
        press(5'b0, M_INT);
        check("R2 R3 INT flag", edges, M_INT);
        check("R5 INT held", held, M_INT);
        sample(5'b0, M_INT);
        check("R4 flag sticky while held", edges, M_INT);
        clear(M_INT);
        check("R4 flag cleared", edges, 0);
        sample(5'b0, M_INT);
        check("R2 no repeat while held", edges, 0);
    endtask

    task automatic t_bounce;
        sample(5'b0, 5'b0); sample(5'b0, 5'b0); sample(5'b0, 5'b0);
        sample(5'b0, M_INT);
        check("R2 short release run ignored", edges, 0);
        check("R5 held after bounce", held, M_INT);
        for (int i = 0; i < HW; i++) sample(5'b0, 5'b0);
        check("R5 released", held, 0);
    endtask

    task automatic t_right;
        press(5'b0, M_RIGHT);
        check("R3 RIGHT flag position", edges, M_RIGHT);
        clear(M_RIGHT);
        sample(5'b0, 5'b0);
    endtask

    task automatic t_chord;
        sample(M_LEFT | M_RIGHT, 5'b0);
        clear('1);
        check("R5 chord held", held, M_LEFT | M_RIGHT);
        press(M_LEFT | M_RIGHT, M_UP);
        check("R6 up step", bright, 14);
        check("R7 store pulse", store, 1);
        check("R7 store value", sval, 14);
        check("R9 UP absorbed", edges & M_UP, 0);
        press(M_LEFT | M_RIGHT, M_UP);
        check("R6 up to top", bright, 15);
        check("R7 store at top", store, 1);
        press(M_LEFT | M_RIGHT, M_UP);
        check("R8 ceiling holds", bright, 15);
        check("R8 no store at ceiling", store, 0);
        press(M_LEFT | M_RIGHT, M_DOWN);
        check("R6 down step", bright, 14);
        check("R7 store down value", sval, 14);
        check("R9 DOWN absorbed", edges & M_DOWN, 0);
        @(negedge clk);
        check("R7 store one cycle", store, 0);
    endtask

    task automatic t_no_chord;
        sample(5'b0, 5'b0);
        clear('1);
        press(5'b0, M_UP);
        check("R6 UP without chord flags", edges, M_UP);
        check("R6 UP without chord level", bright, 14);
        check("R6 no store without chord", store, 0);
        clear(M_UP);
    endtask

    task automatic t_floor;
        for (int i = 0; i < 14; i++) press(M_LEFT | M_RIGHT, M_DOWN);
        check("R8 reach floor", bright, 0);
        press(M_LEFT | M_RIGHT, M_DOWN);
        check("R8 floor holds", bright, 0);
        check("R8 no store at floor", store, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_no_tick();
        t_int_press();
        t_bounce();
        t_right();
        t_chord();
        t_no_chord();
        t_floor();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule